// File: doc/BRIEF.md
# March C- Memory Self-Test Engine

This block runs the March C- test on one single-port synchronous SRAM. When idle it passes a functional address, write strobe, read strobe and write word straight through to the memory pins. After a start pulse it takes over those pins and issues the six march elements, one memory operation per clock. Each read result is compared with its expected word one cycle after the read is issued, and that compare overlaps the next operation. A mismatch sets a fail flag that stays set until the next start. When the last compare is done, a done flag rises and stays high until the next start. A hold input pauses the engine at any point and keeps its position.

The two data values of the march are taken from a word-wide background input. "0" is the background word and "1" is its bitwise inverse. The memory side is a plain fixed-latency SRAM port, not a stream. Read data must be valid in the cycle after a read strobe, and the memory never applies back-pressure. The engine creates back-pressure only through hold: while hold is high, no operation is issued and nothing advances.

Top module: `march_bist`

## Requirements
- R1: The engine runs the elements in this order, with B = background word and ~B = its inverse:
  - E0 ascending write B.
  - E1 ascending (read B, write ~B).
  - E2 ascending (read ~B, write B).
  - E3 descending (read B, write ~B).
  - E4 descending (read ~B, write B).
  - E5 ascending read B.
- R2: A run issues exactly 10·DEPTH operations. It issues one per cycle while hold is low, and never asserts write and read strobes together.
- R3: Ascending elements visit addresses 0 to DEPTH-1 and descending elements visit DEPTH-1 down to 0. All operations of one address complete before the address changes.
- R4: While hold is high during a run, both strobes are low and the sequence resumes at the same operation once hold falls.
- R5: Read data is compared in the cycle after the read. A mismatch makes fail high two cycles after the read was issued. Fail stays high until a start is accepted, and that start clears it.
- R6: Done is low in the cycle after the final read and high in the cycle after that, together with the final fail value. Done then stays high until the next accepted start.
- R7: A start pulse during a run (including its final compare cycle) is ignored. Start is accepted only when the engine is idle or done.
- R8: When the engine is idle or done, the memory pins equal the functional inputs. During a run the functional inputs have no effect on them.
- R9: After reset, done and fail are low and the engine is idle with the memory pins following the functional inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted when idle or done |
| hold | input | 1 | Pause the run without losing position |
| bg_word | input | DATA_W | Background word ("0"); its inverse is "1" |
| func_addr | input | ADDR_W | Functional address |
| func_we | input | 1 | Functional write strobe |
| func_re | input | 1 | Functional read strobe |
| func_wdata | input | DATA_W | Functional write word |
| mem_addr | output | ADDR_W | Address to memory |
| mem_we | output | 1 | Write strobe to memory |
| mem_re | output | 1 | Read strobe to memory |
| mem_wdata | output | DATA_W | Write word to memory |
| mem_rdata | input | DATA_W | Read word from memory, valid the cycle after mem_re |
| done | output | 1 | Run complete, held until next start |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The bench builds the engine with DEPTH = 6 and DATA_W = 4. A depth that is not a power of two means the descending count starts from a value other than all-ones, and a 60-operation run lets every operation be checked against an arithmetic model. Several backgrounds, hold patterns and injected memory faults (a stuck-at bit and an address alias) are run back to back. This checks the compare latency, the sticky fail and its clearing, the ignored start, and the pass-through between runs.

// File: rtl/march_pkg.sv
package march_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_DONE
  } seq_st_e;

  // One march element: direction and up to two operations
  typedef struct packed {
    logic down;
    logic two_ops;
    logic op0_wr;
    logic op0_inv;
    logic op1_wr;
    logic op1_inv;
  } elem_t;

  localparam int NUM_ELEM = 6;

  function automatic elem_t elem_desc(input logic [2:0] e);
    elem_t d;
    d = '0;
    case (e)
      3'd0: begin d.op0_wr = 1'b1; end
      3'd1: begin d.two_ops = 1'b1; d.op1_wr = 1'b1; d.op1_inv = 1'b1; end
      3'd2: begin d.two_ops = 1'b1; d.op0_inv = 1'b1; d.op1_wr = 1'b1; end
      3'd3: begin d.down = 1'b1; d.two_ops = 1'b1; d.op1_wr = 1'b1; d.op1_inv = 1'b1; end
      3'd4: begin d.down = 1'b1; d.two_ops = 1'b1; d.op0_inv = 1'b1; d.op1_wr = 1'b1; end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hold,
  output logic              start_ok,
  output logic              busy,
  output logic              done,
  output logic              op_valid,
  output logic              op_wr,
  output logic              op_inv,
  output logic [ADDR_W-1:0] op_addr
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [2:0]        LAST_E   = 3'(NUM_ELEM - 1);

  seq_st_e           state_q;
  logic [2:0]        elem_q;
  logic              op_q;
  logic [ADDR_W-1:0] addr_q;

  elem_t d, nd;
  logic  last_op, last_addr, last_elem;

  assign d         = elem_desc(elem_q);
  assign nd        = elem_desc(elem_q + 3'd1);
  assign last_op   = !d.two_ops || op_q;
  assign last_addr = d.down ? (addr_q == '0) : (addr_q == TOP_ADDR);
  assign last_elem = (elem_q == LAST_E);

  assign start_ok = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign busy     = (state_q == ST_RUN) || (state_q == ST_DRAIN);
  assign done     = (state_q == ST_DONE);
  assign op_valid = (state_q == ST_RUN) && !hold;
  assign op_wr    = op_q ? d.op1_wr  : d.op0_wr;
  assign op_inv   = op_q ? d.op1_inv : d.op0_inv;
  assign op_addr  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      op_q    <= 1'b0;
      addr_q  <= '0;
    end else if (start_ok) begin
      state_q <= ST_RUN;
      elem_q  <= '0;
      op_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (!hold) begin
            if (!last_op) begin
              op_q <= 1'b1;
            end else begin
              op_q <= 1'b0;
              if (!last_addr) begin
                addr_q <= d.down ? addr_q - 1'b1 : addr_q + 1'b1;
              end else if (last_elem) begin
                state_q <= ST_DRAIN;
              end else begin
                elem_q <= elem_q + 3'd1;
                addr_q <= nd.down ? TOP_ADDR : '0;
              end
            end
          end
        end
        ST_DRAIN: state_q <= ST_DONE;
        default:  state_q <= state_q;
      endcase
    end
  end

  assert_hold_keeps_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && hold && !start_ok) |=>
      ($stable(addr_q) && $stable(elem_q) && $stable(op_q)));

  assert_desc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && d.down && last_op && !last_addr) |=> (addr_q == $past(addr_q) - 1'b1));

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= TOP_ADDR);

  assert_done_after_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state_q == ST_DRAIN));

endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] rd_exp,
  input  logic [DATA_W-1:0] rdata,
  output logic              fail
);

  logic              pend_q;
  logic [DATA_W-1:0] exp_q;
  logic              fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      exp_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      pend_q <= rd_issue;
      if (rd_issue) exp_q <= rd_exp;
      if (clear)                             fail_q <= 1'b0;
      else if (pend_q && (rdata != exp_q))   fail_q <= 1'b1;
    end
  end

  assign fail = fail_q;

  assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clear) |=> fail_q);

  assert_fail_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> $past(pend_q));

endmodule

// File: rtl/march_mux.sv
module march_mux #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              sel_test,
  input  logic [ADDR_W-1:0] t_addr,
  input  logic              t_we,
  input  logic              t_re,
  input  logic [DATA_W-1:0] t_wdata,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic              f_we,
  input  logic              f_re,
  input  logic [DATA_W-1:0] f_wdata,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_we,
  output logic              m_re,
  output logic [DATA_W-1:0] m_wdata
);

  always_comb begin
    if (sel_test) begin
      m_addr  = t_addr;
      m_we    = t_we;
      m_re    = t_re;
      m_wdata = t_wdata;
    end else begin
      m_addr  = f_addr;
      m_we    = f_we;
      m_re    = f_re;
      m_wdata = f_wdata;
    end
  end

endmodule

// File: rtl/march_bist.sv
module march_bist #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hold,
  input  logic [DATA_W-1:0] bg_word,
  input  logic [ADDR_W-1:0] func_addr,
  input  logic              func_we,
  input  logic              func_re,
  input  logic [DATA_W-1:0] func_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              fail
);

  logic              start_ok, busy, op_valid, op_wr, op_inv;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;

  march_seq #(.DEPTH(DEPTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .hold     (hold),
    .start_ok (start_ok),
    .busy     (busy),
    .done     (done),
    .op_valid (op_valid),
    .op_wr    (op_wr),
    .op_inv   (op_inv),
    .op_addr  (op_addr)
  );

  assign op_data = op_inv ? ~bg_word : bg_word;

  march_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_ok),
    .rd_issue (op_valid && !op_wr),
    .rd_exp   (op_data),
    .rdata    (mem_rdata),
    .fail     (fail)
  );

  march_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .sel_test (busy),
    .t_addr   (op_addr),
    .t_we     (op_valid && op_wr),
    .t_re     (op_valid && !op_wr),
    .t_wdata  (op_data),
    .f_addr   (func_addr),
    .f_we     (func_we),
    .f_re     (func_re),
    .f_wdata  (func_wdata),
    .m_addr   (mem_addr),
    .m_we     (mem_we),
    .m_re     (mem_re),
    .m_wdata  (mem_wdata)
  );

  assert_single_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(mem_we && mem_re));

  assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hold) |-> (!mem_we && !mem_re));

  assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_we == func_we && mem_re == func_re && mem_addr == func_addr));

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/march_bist_bench.sv
module march_bist_bench;

  localparam int CLK_P = 10;
  localparam int DEPTH = 6;
  localparam int DW    = 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int NOPS  = 10 * DEPTH;
  localparam int FA    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, hold = 1'b0;
  logic [DW-1:0] bg_word = '0;
  logic [AW-1:0] func_addr = '0;
  logic          func_we = 1'b0, func_re = 1'b0;
  logic [DW-1:0] func_wdata = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          done, fail;

  int n_chk = 0, n_bad = 0, cyc = 0, fault = 0;
  logic [DW-1:0] mem [0:DEPTH-1];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural SRAM with injectable faults
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (fault == 2 && mem_addr == AW'(2)) mem[4] <= mem_wdata;
    end
    if (mem_re) begin
      if (fault == 1 && mem_addr == AW'(FA)) mem_rdata <= mem[mem_addr] | DW'(1);
      else                                   mem_rdata <= mem[mem_addr];
    end
  end

  march_bist #(.DEPTH(DEPTH), .DATA_W(DW)) u_march_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .hold(hold), .bg_word(bg_word),
    .func_addr(func_addr), .func_we(func_we), .func_re(func_re), .func_wdata(func_wdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .fail(fail)
  );

  task automatic check(input bit ok, input string msg, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, expv);
    end
  endtask

  // Arithmetic model of operation k of the march
  task automatic exp_op(input int k, input logic [DW-1:0] bg,
                        output bit wr, output int addr, output logic [DW-1:0] data);
    int e, j, base;
    bit inv, down;
    if (k < DEPTH) begin
      wr = 1; addr = k; data = bg; return;
    end
    if (k >= 9 * DEPTH) begin
      wr = 0; addr = k - 9 * DEPTH; data = bg; return;
    end
    e    = (k - DEPTH) / (2 * DEPTH) + 1;
    base = DEPTH + (e - 1) * 2 * DEPTH;
    j    = k - base;
    down = (e >= 3);
    wr   = (j % 2) == 1;
    addr = down ? DEPTH - 1 - j / 2 : j / 2;
    inv  = ((e == 1 || e == 3) ? 1'b0 : 1'b1) ^ wr;
    data = inv ? ~bg : bg;
  endtask

  task automatic run_march(input int flt, input logic [DW-1:0] bg, input bit use_hold,
                           input bit poke, input int bad_k, input bit exp_fail);
    int k = 0, guard = 0, first_c = -1, last_c = -1, bad_c = -100;
    bit ewr; int eaddr; logic [DW-1:0] edata;
    string tag;
    fault = flt; bg_word = bg;
    func_we = 1'b1; func_re = 1'b0; func_addr = AW'(1); func_wdata = ~bg;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    #1;
    check(fail == 1'b0, "R5 fail cleared by accepted start", fail, 0);
    check(done == 1'b0, "R6 done low after start", done, 0);
    while (k < NOPS && guard < 4 * NOPS) begin
      if (cyc == bad_c + 1) check(fail == 1'b0, "R5 fail not before compare", fail, 0);
      if (cyc == bad_c + 2) check(fail == 1'b1, "R5 fail two cycles after bad read", fail, 1);
      hold  = use_hold && (guard % 4 == 2);
      start = poke && (k == 20);
      #1;
      if (hold) begin
        check(!mem_we && !mem_re, "R4 no operation while held", {mem_we, mem_re}, 0);
      end else begin
        exp_op(k, bg, ewr, eaddr, edata);
        tag = (poke && k > 20) ? "R7 sequence unchanged after ignored start" : "R1 R3 operation";
        check(mem_we == ewr && mem_re == !ewr, {tag, " strobes"}, {mem_we, mem_re}, {ewr, !ewr});
        check(int'(mem_addr) == eaddr, {tag, " address"}, mem_addr, eaddr);
        if (ewr) check(mem_wdata == edata, {tag, " write data"}, mem_wdata, edata);
        if (k == bad_k) bad_c = cyc;
        if (first_c < 0) first_c = cyc;
        last_c = cyc;
        k++;
      end
      @(negedge clk);
      guard++;
    end
    hold = 1'b0; start = 1'b0;
    #1;
    check(k == NOPS, "R2 operation count", k, NOPS);
    if (!use_hold) check(last_c - first_c + 1 == NOPS, "R2 one op per cycle", last_c - first_c + 1, NOPS);
    check(done == 1'b0, "R6 done low during final compare", done, 0);
    check(!mem_we && !mem_re, "R2 no extra operation", {mem_we, mem_re}, 0);
    @(negedge clk); #1;
    check(done == 1'b1, "R6 done high after final compare", done, 1);
    check(fail == exp_fail, "R5 final fail value", fail, exp_fail);
    @(negedge clk); #1;
    check(done == 1'b1, "R6 done held", done, 1);
    check(mem_we == func_we && mem_addr == func_addr && mem_wdata == func_wdata,
          "R8 pass-through when done", mem_addr, func_addr);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    func_addr = AW'(5); func_we = 1'b1; func_re = 1'b0; func_wdata = 4'h9;
    repeat (3) @(negedge clk);
    #1;
    check(done == 1'b0 && fail == 1'b0, "R9 reset flags", {done, fail}, 0);
    check(mem_addr == AW'(5) && mem_we && mem_wdata == 4'h9, "R9 reset pass-through", mem_addr, 5);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(done == 1'b0, "R9 idle after reset", done, 0);
    func_re = 1'b1; func_we = 1'b0; func_addr = AW'(2); #1;
    check(mem_re && !mem_we && mem_addr == AW'(2), "R8 idle pass-through", mem_addr, 2);
    hold = 1'b1; @(negedge clk); hold = 1'b0; #1;
    check(done == 1'b0 && !mem_we, "R4 hold ignored when idle", done, 0);

    run_march(0, 4'h0, 1'b0, 1'b0, -1, 1'b0);
    run_march(0, 4'hA, 1'b1, 1'b0, -1, 1'b0);
    run_march(1, 4'h0, 1'b0, 1'b1, DEPTH + 2 * FA, 1'b1);
    run_march(0, 4'h3, 1'b0, 1'b0, -1, 1'b0);
    run_march(2, 4'h5, 1'b1, 1'b0, -1, 1'b1);
    run_march(0, 4'hF, 1'b1, 1'b1, -1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule